// File: doc/BRIEF.md
# Ethernet Receive Frame Status Generator

This block sits beside the byte-wide receive path of an Ethernet MAC and produces one packed status word for each received frame. It counts the bytes of the frame and classifies the destination address. It records whether the frame check failed or the PHY reported a receive error. It then flags odd byte counts and frames whose length on the wire is outside the legal range. It does not compute the CRC. A CRC-good flag arrives from the checker upstream on the last byte of the frame.

A frame opens with a valid byte carrying the start strobe and closes with a valid byte carrying the end strobe. These can be the same byte. One cycle after the closing byte, the block presents the status word together with a single-cycle valid pulse. The receive-error input is watched on every cycle of the frame, including idle cycles between bytes. Every flag is cleared when the next frame opens.

Top module: `rx_frame_status`

## Requirements
- R1: The status word is 17 bits. Bit 16 is broadcast, bit 15 multicast, bit 14 bad CRC, bit 13 odd count, bit 12 too long and bit 11 too short. Bits 10:0 hold the byte count, which covers every valid byte from the start byte through the end byte inclusive and saturates at 2047.
- R2: `stat_valid` is high for exactly one cycle: the cycle after a valid byte with `in_eof` that belongs to an open frame. The word shown in that cycle describes that frame.
- R3: The broadcast flag is set only when the first six bytes of the frame are all 0xFF.
- R4: The multicast flag is set when bit 0 of the first byte is 1 and the broadcast flag is clear.
- R5: The bad CRC flag is set when `crc_ok` is low on the end byte. It is also set when `phy_err` is high on any cycle from the start byte through the end byte, idle cycles included. `phy_err` outside a frame has no effect.
- R6: The odd flag is set when the true byte count is odd. This still holds after the count field has saturated.
- R7: The too-long flag is set when the byte count exceeds 1518.
- R8: The too-short flag is set when the byte count is below 64.
- R9: Cycles with `in_valid` low are not counted. Valid bytes that arrive without `in_sof` while no frame is open are ignored and produce no status. A start byte inside an open frame discards that frame and begins a new one.
- R10: During and after reset, `stat_valid` is low and `stat_word` is zero until the first frame closes.
- R11: A frame can start in the same cycle that the previous frame's status is shown. The shown word is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive byte valid |
| in_sof | input | 1 | First byte of frame (qualified by in_valid) |
| in_eof | input | 1 | Last byte of frame (qualified by in_valid) |
| in_data | input | 8 | Receive byte |
| phy_err | input | 1 | PHY receive error |
| crc_ok | input | 1 | Frame check good, sampled on the end byte |
| stat_valid | output | 1 | Status word valid pulse |
| stat_word | output | 17 | Packed frame status |

## Verification
Two events can fall in the same cycle. In one cycle the status of a finished frame is on the outputs, and the clearing start byte of the next frame is on the inputs. The bench provokes this by sending two frames back to back with no idle cycle between them. The first frame is built to set several flags and the second to set none, so the shown word can be compared bit for bit with the first frame's expected value. A second case is a single-byte frame, where opening and closing happen on the same byte.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

    localparam int unsigned LEN_W = 11;

    typedef struct packed {
        logic             bcast;
        logic             mcast;
        logic             bad_crc;
        logic             odd;
        logic             too_long;
        logic             too_short;
        logic [LEN_W-1:0] len;
    } rx_stat_t;

    localparam int unsigned STAT_W = $bits(rx_stat_t);

    function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/rxfs_len_ctr.sv
module rxfs_len_ctr
    import rxfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic             restart,
    output logic [LEN_W-1:0] cnt_nx,
    output logic             par_nx
);
    logic [LEN_W-1:0] cnt_q;
    logic             par_q;

    always_comb begin
        if (restart) begin
            cnt_nx = LEN_W'(1);
            par_nx = 1'b1;
        end else if (beat) begin
            cnt_nx = sat_inc(cnt_q);
            par_nx = ~par_q;
        end else begin
            cnt_nx = cnt_q;
            par_nx = par_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            par_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            par_q <= par_nx;
        end
    end
endmodule

// File: rtl/rxfs_da_class.sv
module rxfs_da_class #(
    parameter int unsigned DA_BYTES = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       beat,
    input  logic       restart,
    input  logic [7:0] data,
    output logic       bcast_nx,
    output logic       grp_nx
);
    localparam int unsigned PW = $clog2(DA_BYTES + 1);
    localparam logic [PW-1:0] LAST = PW'(DA_BYTES);

    logic [PW-1:0] pos_q, pos_cur, pos_nx;
    logic          ones_q, ones_nx;
    logic          grp_q;

    always_comb begin
        pos_cur = restart ? '0 : pos_q;
        pos_nx  = pos_cur;
        ones_nx = ones_q;
        grp_nx  = grp_q;
        if (beat && (pos_cur < LAST)) begin
            pos_nx  = pos_cur + 1'b1;
            ones_nx = ((pos_cur == '0) ? 1'b1 : ones_q) & (&data);
            if (pos_cur == '0) begin
                grp_nx = data[0];
            end
        end
        bcast_nx = ones_nx && (pos_nx == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else begin
            pos_q  <= pos_nx;
            ones_q <= ones_nx;
            grp_q  <= grp_nx;
        end
    end
endmodule

// File: rtl/rxfs_err_latch.sv
module rxfs_err_latch (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic frame_open,
    input  logic phy_err,
    output logic err_nx
);
    logic err_q;

    assign err_nx = restart ? phy_err : (err_q | (frame_open & phy_err));

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_nx;
        end
    end
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
    import rxfs_pkg::*;
#(
    parameter int unsigned MIN_LEN  = 64,
    parameter int unsigned MAX_LEN  = 1518,
    parameter int unsigned DA_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic              phy_err,
    input  logic              crc_ok,
    output logic              stat_valid,
    output logic [STAT_W-1:0] stat_word
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    logic             frame_open_q;
    logic             restart, beat_ok, close;
    logic [LEN_W-1:0] cnt_nx;
    logic             par_nx, bcast_nx, grp_nx, err_nx;
    rx_stat_t         stat_d, stat_q;
    logic             vld_q;

    assign restart = in_valid & in_sof;
    assign beat_ok = in_valid & (in_sof | frame_open_q);
    assign close   = beat_ok & in_eof;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_open_q <= 1'b0;
        end else if (close) begin
            frame_open_q <= 1'b0;
        end else if (restart) begin
            frame_open_q <= 1'b1;
        end
    end

    rxfs_len_ctr u_len (
        .clk     (clk),
        .rst     (rst),
        .beat    (beat_ok),
        .restart (restart),
        .cnt_nx  (cnt_nx),
        .par_nx  (par_nx)
    );

    rxfs_da_class #(.DA_BYTES(DA_BYTES)) u_da (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat_ok),
        .restart  (restart),
        .data     (in_data),
        .bcast_nx (bcast_nx),
        .grp_nx   (grp_nx)
    );

    rxfs_err_latch u_err (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .frame_open (frame_open_q),
        .phy_err    (phy_err),
        .err_nx     (err_nx)
    );

    always_comb begin
        stat_d.bcast     = bcast_nx;
        stat_d.mcast     = grp_nx & ~bcast_nx;
        stat_d.bad_crc   = ~crc_ok | err_nx;
        stat_d.odd       = par_nx;
        stat_d.too_long  = cnt_nx > MAX_L;
        stat_d.too_short = cnt_nx < MIN_L;
        stat_d.len       = cnt_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= close;
            if (close) begin
                stat_q <= stat_d;
            end
        end
    end

    assign stat_valid = vld_q;
    assign stat_word  = stat_q;
endmodule

// File: rtl/rxfs_chk.sv
module rxfs_chk
    import rxfs_pkg::*;
#(
    parameter int unsigned MIN_LEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sof,
    input logic              in_eof,
    input logic              crc_ok,
    input logic              frame_open,
    input logic              stat_valid,
    input logic [STAT_W-1:0] stat_word
);
    rx_stat_t st;
    logic     closing;
    assign st      = stat_word;
    assign closing = in_valid && in_eof && (in_sof || frame_open);

    // R2
    vld_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        closing |=> stat_valid);

    // R2
    vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $past(closing));

    // R5
    crc_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (closing && !crc_ok) |=> st.bad_crc);

    // R4
    cls_excl_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !(st.bcast && st.mcast));

    // R7
    len_excl_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !(st.too_long && st.too_short));

    // R6
    odd_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && !(&st.len)) |-> (st.odd == st.len[0]));

    // R8
    short_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (st.too_short == (st.len < LEN_W'(MIN_LEN))));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!stat_valid && stat_word == '0));
endmodule

bind rx_frame_status rxfs_chk #(.MIN_LEN(MIN_LEN)) u_rxfs_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .crc_ok     (crc_ok),
    .frame_open (frame_open_q),
    .stat_valid (stat_valid),
    .stat_word  (stat_word)
);

// File: tb/rx_frame_status_bench.sv
module rx_frame_status_bench;
    import rxfs_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              phy_err = 1'b0, crc_ok = 1'b1;
    logic              stat_valid;
    logic [STAT_W-1:0] stat_word;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rx_frame_status u_rx_frame_status (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .phy_err(phy_err),
        .crc_ok(crc_ok), .stat_valid(stat_valid), .stat_word(stat_word)
    );

    // mode: 0 unicast, 1 broadcast, 2 multicast
    function automatic logic [7:0] gen(int mode, int i);
        if (i < 6) begin
            if (mode == 1) return 8'hFF;
            if (mode == 2) return (i == 0) ? 8'h01 : 8'h5E;
            return (i == 0) ? 8'h02 : 8'(8'h10 + i);
        end
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic logic [STAT_W-1:0] expw(int len, int mode, bit crc, bit err);
        logic bc, mc;
        logic [LEN_W-1:0] lf;
        bc = (mode == 1) && (len >= 6);
        mc = (mode != 0) && !bc;
        lf = (len > 2047) ? 11'd2047 : LEN_W'(len);
        return {bc, mc, (!crc || err), (len % 2 == 1), (len > 1518), (len < 64), lf};
    endfunction

    task automatic beat(input logic [7:0] d, input logic s, input logic e, input bit crc);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        phy_err = 1'b0; crc_ok = crc;
    endtask

    task automatic idle(input logic err);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; phy_err = err;
    endtask

    task automatic check_word(input string req, input logic [STAT_W-1:0] exp);
        @(negedge clk);
        checks++;
        if (!stat_valid || stat_word !== exp) begin
            fails++;
            $display("FAIL %s: valid=%0b word=%h expected valid=1 word=%h", req, stat_valid, stat_word, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        @(negedge clk);
        checks++;
        if (stat_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: valid=%0b expected 0", req, stat_valid);
        end
    endtask

    // Drives a frame; optional idle error gap before byte err_at; optional
    // check of the previous frame's status after the first byte.
    task automatic send_frame(input int len, input int mode, input bit crc, input int err_at,
                              input bit chk_prev, input logic [STAT_W-1:0] prev_exp);
        for (int i = 0; i < len; i++) begin
            if (i == err_at && i > 0) idle(1'b1);
            beat(gen(mode, i), i == 0, i == len - 1, crc);
            if (i == 0 && chk_prev) check_word("R11 back-to-back", prev_exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        checks++;
        if (stat_valid !== 1'b0 || stat_word !== '0) begin
            fails++;
            $display("FAIL R10: valid=%0b word=%h expected 0/0", stat_valid, stat_word);
        end
    endtask

    task automatic t_single(input string req, input int len, input int mode, input bit crc, input int err_at);
        send_frame(len, mode, crc, err_at, 1'b0, '0);
        idle(1'b0);
        check_word(req, expw(len, mode, crc, err_at > 0));
    endtask

    task automatic t_pulse_once;
        send_frame(80, 0, 1'b1, -1, 1'b0, '0);
        idle(1'b0);
        check_word("R2 pulse", expw(80, 0, 1'b1, 1'b0));
        idle(1'b0);
        check_quiet("R2 one cycle only");
    endtask

    task automatic t_outside_err;
        idle(1'b1);
        idle(1'b1);
        send_frame(70, 0, 1'b1, -1, 1'b0, '0);
        idle(1'b1);
        check_word("R5 phy_err outside frame ignored", expw(70, 0, 1'b1, 1'b0));
        idle(1'b0);
    endtask

    task automatic t_stray;
        beat(8'h33, 1'b0, 1'b0, 1'b1);
        beat(8'h44, 1'b0, 1'b1, 1'b1);
        idle(1'b0);
        check_quiet("R9 stray bytes no status");
        send_frame(66, 2, 1'b1, -1, 1'b0, '0);
        idle(1'b0);
        check_word("R9 count after stray", expw(66, 2, 1'b1, 1'b0));
    endtask

    task automatic t_gaps;
        for (int i = 0; i < 65; i++) begin
            beat(gen(0, i), i == 0, i == 64, 1'b1);
            if (i % 7 == 3) idle(1'b0);
        end
        idle(1'b0);
        check_word("R9 idle cycles not counted", expw(65, 0, 1'b1, 1'b0));
    endtask

    task automatic t_restart;
        for (int i = 0; i < 10; i++) beat(gen(1, i), i == 0, 1'b0, 1'b1);
        idle(1'b1);
        send_frame(90, 0, 1'b1, -1, 1'b0, '0);
        idle(1'b0);
        check_word("R9 restart discards partial frame", expw(90, 0, 1'b1, 1'b0));
    endtask

    task automatic t_b2b;
        send_frame(63, 1, 1'b0, 20, 1'b0, '0);
        send_frame(64, 0, 1'b1, -1, 1'b1, expw(63, 1, 1'b0, 1'b1));
        idle(1'b0);
        check_word("R11 second frame clean", expw(64, 0, 1'b1, 1'b0));
    endtask

    task automatic t_one_byte;
        beat(8'hFF, 1'b1, 1'b1, 1'b1);
        idle(1'b0);
        check_word("R3 R8 single byte frame", expw(1, 1, 1'b1, 1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #1 rst = 1'b0;
        t_reset();
        t_single("R8 R1 minimum unicast", 64, 0, 1'b1, -1);
        t_single("R8 R6 63 bytes", 63, 0, 1'b1, -1);
        t_single("R3 R7 1518 broadcast", 1518, 1, 1'b1, -1);
        t_single("R7 R6 1519 bytes", 1519, 0, 1'b1, -1);
        t_single("R4 multicast", 100, 2, 1'b1, -1);
        t_single("R5 crc fail", 200, 0, 1'b0, -1);
        t_single("R5 phy_err between bytes", 128, 0, 1'b1, 50);
        t_single("R1 R6 saturation", 2100, 0, 1'b1, -1);
        t_single("R1 R6 saturation odd", 2101, 2, 1'b1, -1);
        t_single("R3 short broadcast-like", 5, 1, 1'b1, -1);
        t_pulse_once();
        t_outside_err();
        t_stray();
        t_gaps();
        t_restart();
        t_b2b();
        t_one_byte();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule